// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address of an 8-bit accumulator CPU once the opcode has been decoded. On a request strobe it takes the decoded addressing mode, a prebyte flag, the first and second bytes after the opcode, the two index registers, the instruction start address and the resolved branch condition. One clock later it presents the operand address, a valid flag, the address of the next instruction to execute and the instruction length in bytes.

The `pc_i` input holds the address of the first byte of the instruction: the prebyte when there is one, otherwise the opcode. The byte after the opcode therefore sits at `pc_i + pre_i + 1`. Sequencing logic uses `tgt_o` as the new program counter. For a branch that is taken it is the branch destination, and in every other case it is the next sequential address. All address arithmetic wraps modulo 65536.

Mode codes on `mode_i`: 0 immediate, 1 direct, 2 extended, 3 indexed, 4 inherent, 5 relative. Codes 6 and 7 are undefined and behave as inherent.

Top module: `opaddr_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, the following edge leaves `vld_o`=0, `ea_o`=0, `tgt_o`=0 and `len_o`=0.
- R2: `vld_o` is 1 in the cycle after a `req_i` strobe whose mode is 0, 1, 2, 3 or 5. It is 0 in the cycle after any edge without `req_i`.
- R3: Direct mode (1) gives `ea_o` = {8'h00, b1_i}.
- R4: Extended mode (2) gives `ea_o` = {b1_i, b2_i}, with b1_i as the high byte.
- R5: Indexed mode (3) gives `ea_o` = base + zero-extended b1_i, modulo 65536. The base is `iy_i` when `pre_i`=1 and `ix_i` when `pre_i`=0.
- R6: Immediate mode (0) gives `ea_o` = `pc_i` + `pre_i` + 1, modulo 65536.
- R7: Relative mode (5) gives `tgt_o` = `pc_i` + `len_o` + sign-extended b1_i when `cond_i`=1, and `tgt_o` = `pc_i` + `len_o` when `cond_i`=0. In both cases the result is modulo 65536 and `ea_o` equals `tgt_o`.
- R8: Inherent mode (4) and the undefined codes 6 and 7 give `vld_o`=0 and `ea_o`=0 after the strobe, while `len_o` and `tgt_o` still update.
- R9: `len_o` is 1 for inherent and undefined codes, 2 for immediate, direct, indexed and relative, and 3 for extended. One is added when `pre_i`=1. In every mode except relative, `tgt_o` = `pc_i` + `len_o`.
- R10: At an edge without `req_i`, `ea_o`, `tgt_o` and `len_o` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; registers a new result |
| mode_i | input | 3 | Decoded addressing mode code |
| pre_i | input | 1 | Prebyte present; also selects IY in indexed mode |
| cond_i | input | 1 | Branch condition result |
| b1_i | input | 8 | First byte after the opcode |
| b2_i | input | 8 | Second byte after the opcode |
| ix_i | input | 16 | Index register X |
| iy_i | input | 16 | Index register Y |
| pc_i | input | 16 | Address of the first instruction byte |
| vld_o | output | 1 | Operand address valid |
| ea_o | output | 16 | Effective operand address |
| tgt_o | output | 16 | Next program counter value |
| len_o | output | 3 | Instruction length in bytes |

## Verification
The bench goes after the places where wrong sign or zero handling would hide. It uses negative branch offsets, which a design that zero-extends would send forward. It uses offsets 0x80 and above in indexed mode, which a sign-extending design would turn into a backward address. It uses sums that carry across the 16-bit boundary, where a design that saturates or keeps the carry would produce a wrong address.

The prebyte flag is exercised in every mode, to catch a length table that is off by one or an indexed mode that reads the wrong index register. Inherent and undefined codes are checked for a zero address with valid low. Idle cycles are checked for outputs that move without a request.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
    typedef enum logic [2:0] {
        AM_IMM = 3'd0,
        AM_DIR = 3'd1,
        AM_EXT = 3'd2,
        AM_IDX = 3'd3,
        AM_INH = 3'd4,
        AM_REL = 3'd5
    } amode_e;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 3;
endpackage

// File: rtl/opaddr_len.sv
module opaddr_len
    import opaddr_pkg::*;
#(
    parameter int unsigned LW = LEN_W
) (
    input  logic [2:0]    mode_i,
    input  logic          pre_i,
    output logic [LW-1:0] len_o
);
    logic [LW-1:0] base_len;

    always_comb begin
        case (amode_e'(mode_i))
            AM_IMM, AM_DIR, AM_IDX, AM_REL: base_len = LW'(2);
            AM_EXT:                         base_len = LW'(3);
            default:                        base_len = LW'(1);
        endcase
        len_o = base_len + LW'(pre_i);
    end
endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic [2:0]    mode_i,
    input  logic          pre_i,
    input  logic          cond_i,
    input  logic [DW-1:0] b1_i,
    input  logic [DW-1:0] b2_i,
    input  logic [AW-1:0] ix_i,
    input  logic [AW-1:0] iy_i,
    input  logic [AW-1:0] pc_i,
    input  logic [LW-1:0] len_i,
    output logic          has_ea_o,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] tgt_o
);
    localparam int unsigned EXT_W = AW - DW;

    logic [AW-1:0] seq_addr;
    logic [AW-1:0] off_sx;
    logic [AW-1:0] off_zx;
    logic [AW-1:0] idx_base;
    logic [AW-1:0] br_addr;

    always_comb begin
        seq_addr = pc_i + AW'(len_i);
        off_sx   = {{EXT_W{b1_i[DW-1]}}, b1_i};
        off_zx   = {{EXT_W{1'b0}}, b1_i};
        idx_base = pre_i ? iy_i : ix_i;
        br_addr  = cond_i ? (seq_addr + off_sx) : seq_addr;

        has_ea_o = 1'b1;
        ea_o     = '0;
        tgt_o    = seq_addr;
        case (amode_e'(mode_i))
            AM_IMM: ea_o = pc_i + AW'(pre_i) + AW'(1);
            AM_DIR: ea_o = off_zx;
            AM_EXT: ea_o = AW'({b1_i, b2_i});
            AM_IDX: ea_o = idx_base + off_zx;
            AM_REL: begin
                ea_o  = br_addr;
                tgt_o = br_addr;
            end
            default: has_ea_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_i,
    input  logic [2:0]    mode_i,
    input  logic          pre_i,
    input  logic          cond_i,
    input  logic [DW-1:0] b1_i,
    input  logic [DW-1:0] b2_i,
    input  logic [AW-1:0] ix_i,
    input  logic [AW-1:0] iy_i,
    input  logic [AW-1:0] pc_i,
    output logic          vld_o,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] tgt_o,
    output logic [LW-1:0] len_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic [AW-1:0] tgt;
        logic [LW-1:0] len;
    } out_t;

    out_t          st_d, st_q;
    logic [LW-1:0] len_w;
    logic          has_ea_w;
    logic [AW-1:0] ea_w;
    logic [AW-1:0] tgt_w;

    opaddr_len #(.LW(LW)) len_i (
        .mode_i (mode_i),
        .pre_i  (pre_i),
        .len_o  (len_w)
    );

    opaddr_calc #(.AW(AW), .DW(DW), .LW(LW)) calc_i (
        .mode_i   (mode_i),
        .pre_i    (pre_i),
        .cond_i   (cond_i),
        .b1_i     (b1_i),
        .b2_i     (b2_i),
        .ix_i     (ix_i),
        .iy_i     (iy_i),
        .pc_i     (pc_i),
        .len_i    (len_w),
        .has_ea_o (has_ea_w),
        .ea_o     (ea_w),
        .tgt_o    (tgt_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (req_i) begin
            st_d.vld = has_ea_w;
            st_d.ea  = has_ea_w ? ea_w : '0;
            st_d.tgt = tgt_w;
            st_d.len = len_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign ea_o  = st_q.ea;
    assign tgt_o = st_q.tgt;
    assign len_o = st_q.len;
endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned LW = 3
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          req_i,
    input logic [2:0]    mode_i,
    input logic          vld_o,
    input logic [AW-1:0] ea_o,
    input logic [AW-1:0] tgt_o,
    input logic [LW-1:0] len_o
);
    // R2
    vld_needs_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |-> ($past(req_i) && !$past(rst_i)));

    // R2
    vld_follows_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(req_i) && !$past(rst_i) && ($past(mode_i) <= 3'd3 || $past(mode_i) == 3'd5))
        |-> vld_o);

    // R8
    no_operand_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(req_i) && !$past(rst_i) && ($past(mode_i) == 3'd4 || $past(mode_i) >= 3'd6))
        |-> (!vld_o && ea_o == '0));

    // R3
    direct_page_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(req_i) && !$past(rst_i) && $past(mode_i) == 3'd1) |-> (ea_o[AW-1:8] == '0));

    // R9
    len_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(req_i) && !$past(rst_i)) |-> (len_o >= LW'(1) && len_o <= LW'(4)));

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(req_i) && !$past(rst_i)) |-> ($stable(ea_o) && $stable(tgt_o) && $stable(len_o)));
endmodule

bind opaddr_gen opaddr_chk #(.AW(AW), .LW(LW)) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (req_i),
    .mode_i (mode_i),
    .vld_o  (vld_o),
    .ea_o   (ea_o),
    .tgt_o  (tgt_o),
    .len_o  (len_o)
);

// File: tb/opaddr_gen_tb.sv
module opaddr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic        pre = 1'b0;
    logic        cond = 1'b0;
    logic [7:0]  b1 = '0, b2 = '0;
    logic [15:0] ix = '0, iy = '0, pc = '0;
    logic        vld;
    logic [15:0] ea, tgt;
    logic [2:0]  len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    opaddr_gen dut_i (
        .clk_i(clk), .rst_i(rst), .req_i(req), .mode_i(mode), .pre_i(pre),
        .cond_i(cond), .b1_i(b1), .b2_i(b2), .ix_i(ix), .iy_i(iy), .pc_i(pc),
        .vld_o(vld), .ea_o(ea), .tgt_o(tgt), .len_o(len)
    );

    function automatic logic [2:0] exp_len(logic [2:0] m, logic p);
        logic [2:0] b;
        case (m)
            3'd0, 3'd1, 3'd3, 3'd5: b = 3'd2;
            3'd2:                   b = 3'd3;
            default:                b = 3'd1;
        endcase
        return b + {2'b0, p};
    endfunction

    function automatic logic exp_vld(logic [2:0] m);
        return (m <= 3'd3) || (m == 3'd5);
    endfunction

    function automatic logic [15:0] exp_tgt(logic [2:0] m, logic p, logic c,
                                            logic [7:0] o, logic [15:0] a);
        logic [15:0] nx;
        nx = a + {13'b0, exp_len(m, p)};
        if (m == 3'd5 && c) return nx + {{8{o[7]}}, o};
        return nx;
    endfunction

    function automatic logic [15:0] exp_ea(logic [2:0] m, logic p, logic c, logic [7:0] o,
                                           logic [7:0] o2, logic [15:0] x, logic [15:0] y,
                                           logic [15:0] a);
        case (m)
            3'd0:    return a + {15'b0, p} + 16'd1;
            3'd1:    return {8'h00, o};
            3'd2:    return {o, o2};
            3'd3:    return (p ? y : x) + {8'h00, o};
            3'd5:    return exp_tgt(m, p, c, o, a);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            3'd0: return "R6";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run(logic [2:0] m, logic p, logic c, logic [7:0] o, logic [7:0] o2,
                       logic [15:0] x, logic [15:0] y, logic [15:0] a);
        logic [15:0] e_ea, e_tg;
        logic [2:0]  e_ln;
        @(negedge clk);
        mode = m; pre = p; cond = c; b1 = o; b2 = o2; ix = x; iy = y; pc = a; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        e_ea = exp_ea(m, p, c, o, o2, x, y, a);
        e_tg = exp_tgt(m, p, c, o, a);
        e_ln = exp_len(m, p);
        chk("R2 vld", {31'b0, vld}, {31'b0, exp_vld(m)});
        chk({mode_tag(m), " ea"}, {16'b0, ea}, {16'b0, e_ea});
        chk("R7 tgt", {16'b0, tgt}, {16'b0, e_tg});
        chk("R9 len", {29'b0, len}, {29'b0, e_ln});
        mode = 3'($urandom); pre = 1'($urandom); b1 = 8'($urandom); pc = 16'($urandom);
        ix = 16'($urandom);
        @(negedge clk);
        chk("R2 idle vld", {31'b0, vld}, 32'd0);
        chk("R10 idle ea", {16'b0, ea}, {16'b0, e_ea});
        chk("R10 idle tgt", {16'b0, tgt}, {16'b0, e_tg});
        chk("R10 idle len", {29'b0, len}, {29'b0, e_ln});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        chk("R1 vld", {31'b0, vld}, 32'd0);
        chk("R1 ea", {16'b0, ea}, 32'd0);
        chk("R1 tgt", {16'b0, tgt}, 32'd0);
        chk("R1 len", {29'b0, len}, 32'd0);
        req = 1'b0;
        rst = 1'b0;
        // directed corner cases
        run(3'd1, 1'b0, 1'b0, 8'hFF, 8'h12, 16'h0, 16'h0, 16'h8000); // R3
        run(3'd2, 1'b1, 1'b0, 8'hAB, 8'hCD, 16'h0, 16'h0, 16'h1000); // R4
        run(3'd3, 1'b0, 1'b0, 8'hF0, 8'h00, 16'hFFF0, 16'h1234, 16'h0); // R5 wrap, IX
        run(3'd3, 1'b1, 1'b0, 8'h80, 8'h00, 16'h1111, 16'h2000, 16'h0); // R5 IY, no sign
        run(3'd0, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0, 16'h0, 16'hFFFE); // R6 wrap
        run(3'd5, 1'b0, 1'b1, 8'hFE, 8'h00, 16'h0, 16'h0, 16'h0100); // R7 backward
        run(3'd5, 1'b0, 1'b1, 8'h7F, 8'h00, 16'h0, 16'h0, 16'hFFF0); // R7 forward wrap
        run(3'd5, 1'b1, 1'b0, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0200); // R7 not taken
        run(3'd5, 1'b0, 1'b1, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0010); // R7 backward wrap
        run(3'd4, 1'b1, 1'b0, 8'h55, 8'h66, 16'h0, 16'h0, 16'h4000); // R8
        run(3'd6, 1'b0, 1'b1, 8'h55, 8'h66, 16'h0, 16'h0, 16'h4000); // R8 undefined
        run(3'd7, 1'b1, 1'b1, 8'h55, 8'h66, 16'h0, 16'h0, 16'h4000); // R8 undefined
        for (int i = 0; i < 400; i++) begin
            run(3'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                16'($urandom), 16'($urandom), 16'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule